// File: doc/BRIEF.md
# Page table entry permission checker

This block judges one leaf page table entry against a pending memory access. It takes the entry, the page size as a bit count, the virtual address, the current privilege level, the kind of access (instruction fetch, data load or data store) and a flag that selects the 32-bit entry layout. It returns a result code. When the access is allowed, it also returns the physical address, a read/write/execute protection mask and the privilege level recorded in the entry.

Faults are ranked in a fixed order, and only the highest-ranked fault is reported. A per-entry restricted-privilege bit tightens the privilege test from "no more privileged than required" to "exactly the recorded level". Bits that software may keep between bit 12 and the page-size boundary are cleared from the frame number before the address is formed. A caller strobes one request at a time, or one on every cycle, and gets each answer registered on the next clock edge.

Top module: `pte_access_check`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and the outputs hold the answer for that request. When `in_valid` is low, `out_valid` is low after the edge. Reset clears `out_valid`, `result`, `pa`, `prot` and `out_plv` to zero.
- R2: The result codes are MATCH=0, INVALID=1, XI=2, RI=3, PE=4 and DIRTY=5. The access codes are fetch=0, load=1 and store=2. Faults are ranked as follows, and only the first one that applies is reported:
  - INVALID: the entry is not present.
  - XI: a fetch of an entry whose no-execute bit is set.
  - RI: a load of an entry whose no-read bit is set.
  - PE: a privilege violation.
  - DIRTY: a store to an entry that is not writable.
  - If none of these applies, the result is MATCH.
- R3: The entry layout is as follows:
  - bit 0: present.
  - bit 1: writable.
  - bits 3:2: entry privilege level.
  - bit 61: no-read.
  - bit 62: no-execute.
  - bit 63: restricted-privilege.
  - In 64-bit mode the frame number is bits PALEN-1:12. Bits above PALEN-1, other than 61 to 63, are ignored.
- R4: With restricted-privilege at 0, PE is raised when `cur_plv` is numerically greater than the entry level. With it at 1, PE is raised whenever the two levels differ.
- R5: With `mode32` high, the no-execute, no-read and restricted-privilege bits are treated as zero, and the frame number is bits 31:12 of the entry, zero-extended.
- R6: The low (`ps` - 12) bits of the frame number are cleared before use.
- R7: On MATCH, `pa` equals the cleaned frame number shifted left by 12, ORed with the low `ps` bits of `va`, truncated to PALEN bits.
- R8: On MATCH, `prot` bit 0 (read) is 1, bit 1 (write) equals the writable bit, and bit 2 (execute) is the inverse of the effective no-execute bit.
- R9: On MATCH, `out_plv` equals the entry privilege level.
- R10: On any fault, `pa`, `prot` and `out_plv` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| entry | input | 64 | Leaf page table entry |
| va | input | 64 | Virtual address of the access |
| ps | input | 6 | Page size as a bit count (12 or more) |
| cur_plv | input | 2 | Current privilege level |
| acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| mode32 | input | 1 | Selects the 32-bit entry layout |
| out_valid | output | 1 | Answer strobe, one cycle after `in_valid` |
| result | output | 3 | Result code |
| pa | output | PALEN | Physical address on MATCH |
| prot | output | 3 | Protection mask: bit 0 read, bit 1 write, bit 2 execute |
| out_plv | output | 2 | Entry privilege level on MATCH |

## Verification
Every result (`result`, `pa`, `prot`, `out_plv` and `out_valid`) passes through exactly one register. Each answer is therefore due on the first rising edge after its strobe. The bench drives each request on a falling edge and samples the outputs on the next falling edge, half a period after the edge that registers them. Requests follow one another on every cycle, so a stale or early value would surface as a mismatch with the neighbouring vector. Idle cycles are inserted to check that `out_valid` drops within that same single cycle.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;

  typedef enum logic [2:0] {
    RES_MATCH   = 3'd0,
    RES_INVALID = 3'd1,
    RES_XI      = 3'd2,
    RES_RI      = 3'd3,
    RES_PE      = 3'd4,
    RES_DIRTY   = 3'd5
  } chk_res_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  localparam int unsigned PAGE_LSB    = 12;
  localparam int unsigned BIT_PRESENT = 0;
  localparam int unsigned BIT_WRITE   = 1;
  localparam int unsigned PLV_LSB     = 2;
  localparam int unsigned BIT_NR      = 61;
  localparam int unsigned BIT_NX      = 62;
  localparam int unsigned BIT_RP      = 63;
  localparam int unsigned FRAME32_MSB = 31;

  // Clear software bits between the 4 KiB boundary and the page-size boundary
  function automatic logic [63:0] strip_sw(input logic [63:0] frame, input logic [5:0] ps);
    logic [5:0] sh;
    sh = (ps > 6'(PAGE_LSB)) ? ps - 6'(PAGE_LSB) : 6'd0;
    return frame & ~((64'd1 << sh) - 64'd1);
  endfunction

  // Page offset part of the virtual address
  function automatic logic [63:0] offset_of(input logic [63:0] va, input logic [5:0] ps);
    return va & ((64'd1 << ps) - 64'd1);
  endfunction

  // Privilege test: exact level when restricted, otherwise "at most"
  function automatic logic plv_denied(input logic [1:0] cur, input logic [1:0] ent, input logic rp);
    return rp ? (cur != ent) : (cur > ent);
  endfunction

endpackage

// File: rtl/pte_field_decode.sv
module pte_field_decode
  import pte_chk_pkg::*;
#(
  parameter int PALEN = 48
) (
  input  logic [63:0] entry,
  input  logic        mode32,
  output logic        present,
  output logic        writable,
  output logic [1:0]  eplv,
  output logic        nx,
  output logic        nr,
  output logic        rp,
  output logic [63:0] frame
);

  assign present  = entry[BIT_PRESENT];
  assign writable = entry[BIT_WRITE];
  assign eplv     = entry[PLV_LSB +: 2];

  // 32-bit layout carries no inhibit or restriction bits
  assign nx = mode32 ? 1'b0 : entry[BIT_NX];
  assign nr = mode32 ? 1'b0 : entry[BIT_NR];
  assign rp = mode32 ? 1'b0 : entry[BIT_RP];

  assign frame = mode32 ? 64'(entry[FRAME32_MSB:PAGE_LSB])
                        : 64'(entry[PALEN-1:PAGE_LSB]);

  logic unused_bits;
  assign unused_bits = ^{entry[PAGE_LSB-1:PLV_LSB+2], entry[BIT_NR-1:PALEN]};

endmodule

// File: rtl/pte_fault_prio.sv
module pte_fault_prio
  import pte_chk_pkg::*;
(
  input  logic       present,
  input  logic       writable,
  input  logic [1:0] eplv,
  input  logic       nx,
  input  logic       nr,
  input  logic       rp,
  input  logic [1:0] cur_plv,
  input  logic [1:0] acc,
  output logic       flt_inv,
  output logic       flt_xi,
  output logic       flt_ri,
  output logic       flt_pe,
  output logic       flt_dirty,
  output chk_res_e   res
);

  // Raw fault conditions, each brought out for the checker
  assign flt_inv   = ~present;
  assign flt_xi    = (acc == ACC_FETCH) & nx;
  assign flt_ri    = (acc == ACC_LOAD) & nr;
  assign flt_pe    = plv_denied(cur_plv, eplv, rp);
  assign flt_dirty = (acc == ACC_STORE) & ~writable;

  always_comb begin
    if (flt_inv)        res = RES_INVALID;
    else if (flt_xi)    res = RES_XI;
    else if (flt_ri)    res = RES_RI;
    else if (flt_pe)    res = RES_PE;
    else if (flt_dirty) res = RES_DIRTY;
    else                res = RES_MATCH;
  end

endmodule

// File: rtl/pte_addr_form.sv
module pte_addr_form
  import pte_chk_pkg::*;
#(
  parameter int PALEN = 48
) (
  input  logic [63:0]      frame,
  input  logic [63:0]      va,
  input  logic [5:0]       ps,
  output logic [PALEN-1:0] pa
);

  logic [63:0] full;

  assign full = (strip_sw(frame, ps) << PAGE_LSB) | offset_of(va, ps);
  assign pa   = full[PALEN-1:0];

  logic unused_hi;
  assign unused_hi = ^full[63:PALEN];

endmodule

// File: rtl/pte_access_check.sv
module pte_access_check
  import pte_chk_pkg::*;
#(
  parameter int PALEN = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [63:0]      entry,
  input  logic [63:0]      va,
  input  logic [5:0]       ps,
  input  logic [1:0]       cur_plv,
  input  logic [1:0]       acc,
  input  logic             mode32,
  output logic             out_valid,
  output logic [2:0]       result,
  output logic [PALEN-1:0] pa,
  output logic [2:0]       prot,
  output logic [1:0]       out_plv
);

  logic             present, writable, nx, nr, rp;
  logic [1:0]       eplv;
  logic [63:0]      frame;
  logic             flt_inv, flt_xi, flt_ri, flt_pe, flt_dirty;
  chk_res_e         res;
  logic [PALEN-1:0] pa_c;
  logic             hit;

  pte_field_decode #(.PALEN(PALEN)) u_dec (
    .entry    (entry),
    .mode32   (mode32),
    .present  (present),
    .writable (writable),
    .eplv     (eplv),
    .nx       (nx),
    .nr       (nr),
    .rp       (rp),
    .frame    (frame)
  );

  pte_fault_prio u_prio (
    .present   (present),
    .writable  (writable),
    .eplv      (eplv),
    .nx        (nx),
    .nr        (nr),
    .rp        (rp),
    .cur_plv   (cur_plv),
    .acc       (acc),
    .flt_inv   (flt_inv),
    .flt_xi    (flt_xi),
    .flt_ri    (flt_ri),
    .flt_pe    (flt_pe),
    .flt_dirty (flt_dirty),
    .res       (res)
  );

  pte_addr_form #(.PALEN(PALEN)) u_addr (
    .frame (frame),
    .va    (va),
    .ps    (ps),
    .pa    (pa_c)
  );

  assign hit = (res == RES_MATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= 3'd0;
      pa        <= '0;
      prot      <= 3'd0;
      out_plv   <= 2'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res;
        pa      <= hit ? pa_c : '0;
        prot    <= hit ? {~nx, writable, 1'b1} : 3'd0;
        out_plv <= hit ? eplv : 2'd0;
      end
    end
  end

endmodule

// File: rtl/pte_access_check_sva.sv
module pte_access_check_sva
  import pte_chk_pkg::*;
#(
  parameter int PALEN = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [63:0]      entry,
  input logic [1:0]       acc,
  input logic             mode32,
  input logic             out_valid,
  input logic [2:0]       result,
  input logic [PALEN-1:0] pa,
  input logic [2:0]       prot,
  input logic [1:0]       out_plv,
  input logic             flt_inv,
  input logic             flt_xi
);

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_ABSENT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !entry[0]) |=> (result == 3'(RES_INVALID))); // R2
  AST_XI_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flt_inv && flt_xi) |=> (result == 3'(RES_XI))); // R2
  AST_DIRTY_STORE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && result == 3'(RES_DIRTY)) |-> ($past(acc) == 2'(ACC_STORE))); // R2
  AST_NARROW_NO_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode32) |=> (result != 3'(RES_XI) && result != 3'(RES_RI))); // R5
  AST_MATCH_READABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && result == 3'(RES_MATCH)) |-> prot[0]); // R8
  AST_MATCH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && result == 3'(RES_MATCH)) |-> (out_plv == $past(entry[3:2]))); // R9
  AST_FAULT_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && result != 3'(RES_MATCH)) |-> (pa == '0 && prot == 3'd0 && out_plv == 2'd0)); // R10

endmodule

bind pte_access_check pte_access_check_sva #(.PALEN(PALEN)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .entry     (entry),
  .acc       (acc),
  .mode32    (mode32),
  .out_valid (out_valid),
  .result    (result),
  .pa        (pa),
  .prot      (prot),
  .out_plv   (out_plv),
  .flt_inv   (flt_inv),
  .flt_xi    (flt_xi)
);

// File: tb/sim_pte_access_check.sv
`timescale 1ns/1ps
module sim_pte_access_check;

  localparam int PALEN = 48;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [63:0]      entry = '0;
  logic [63:0]      va = '0;
  logic [5:0]       ps = 6'd12;
  logic [1:0]       cur_plv = '0;
  logic [1:0]       acc = '0;
  logic             mode32 = 1'b0;
  logic             out_valid;
  logic [2:0]       result;
  logic [PALEN-1:0] pa;
  logic [2:0]       prot;
  logic [1:0]       out_plv;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pte_access_check #(.PALEN(PALEN)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .entry(entry), .va(va),
    .ps(ps), .cur_plv(cur_plv), .acc(acc), .mode32(mode32),
    .out_valid(out_valid), .result(result), .pa(pa), .prot(prot), .out_plv(out_plv)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Independent reference, written arithmetically from the requirements
  task automatic model(input logic [63:0] e, input logic [63:0] v, input int sz,
                       input int cp, input int ak, input bit m32,
                       output int r, output logic [63:0] exp_pa,
                       output int exp_prot, output int exp_lvl);
    int lvl;
    bit ex_in, rd_in, strict, bad_lvl;
    logic [63:0] fr, gran;
    lvl    = int'(e[3:2]);
    ex_in  = m32 ? 1'b0 : e[62];
    rd_in  = m32 ? 1'b0 : e[61];
    strict = m32 ? 1'b0 : e[63];
    bad_lvl = strict ? (cp != lvl) : (cp > lvl);
    if (e[0] == 1'b0)              r = 1;
    else if (ak == 0 && ex_in)     r = 2;
    else if (ak == 1 && rd_in)     r = 3;
    else if (bad_lvl)              r = 4;
    else if (ak == 2 && !e[1])     r = 5;
    else                           r = 0;
    fr   = m32 ? {32'd0, e[31:0]} / 4096 : (e % (64'd1 << PALEN)) / 4096;
    gran = 64'd1 << (sz - 12);
    fr   = fr - (fr % gran);
    exp_pa = (fr * 4096 + (v % (64'd1 << sz))) % (64'd1 << PALEN);
    exp_prot = 1 + (e[1] ? 2 : 0) + (ex_in ? 0 : 4);
    exp_lvl = lvl;
    if (r != 0) begin
      exp_pa = 0;
      exp_prot = 0;
      exp_lvl = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int sizes[6];
    int idx;
    sizes[0] = 12; sizes[1] = 13; sizes[2] = 16;
    sizes[3] = 21; sizes[4] = 25; sizes[5] = 30;
    idx = 0;

    repeat (3) @(negedge clk);
    check("R1 reset out_valid", 64'(out_valid), 64'd0);
    check("R1 reset result", 64'(result), 64'd0);
    check("R1 reset pa", 64'(pa), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 2; m++) begin
      for (int ak = 0; ak < 3; ak++) begin
        for (int bits = 0; bits < 128; bits++) begin
          for (int cp = 0; cp < 4; cp++) begin
            logic [63:0] e, v, epa;
            int r, eprot, elvl, sz;
            string tag;
            e = {$urandom, $urandom};
            v = {$urandom, $urandom};
            // bits: [0]present [1]writable [3:2]level [4]no-read [5]no-exec [6]restricted
            e[0] = bits[0];
            e[1] = bits[1];
            e[3:2] = 2'(bits >> 2);
            e[61] = bits[4];
            e[62] = bits[5];
            e[63] = bits[6];
            sz = sizes[idx % 6];
            idx++;
            entry = e; va = v; ps = 6'(sz); cur_plv = 2'(cp);
            acc = 2'(ak); mode32 = m[0]; in_valid = 1'b1;
            model(e, v, sz, cp, ak, m[0], r, epa, eprot, elvl);
            @(posedge clk);
            @(negedge clk);
            if (r == 4)     tag = "R4 privilege";
            else if (m[0])  tag = "R5 narrow layout";
            else            tag = "R2 R3 priority";
            check("R1 out_valid", 64'(out_valid), 64'd1);
            check(tag, 64'(result), 64'(r));
            check("R6 R7 R10 pa", 64'(pa), epa);
            check("R8 R10 prot", 64'(prot), 64'(eprot));
            check("R9 R10 out_plv", 64'(out_plv), 64'(elvl));
            if ((idx % 97) == 0) begin
              in_valid = 1'b0;
              @(posedge clk);
              @(negedge clk);
              check("R1 idle", 64'(out_valid), 64'd0);
            end
          end
        end
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    finish_up();
  end

endmodule